// File: doc/BRIEF.md
# Sampling-Based Core Selection Controller

This controller chooses which of four cores, all executing the same instruction set, runs the single active process. The aim is lower energy. Two of the cores are simple in-order designs and two are wide out-of-order designs. The controller counts fixed-length execution intervals, and each one is marked by an `interval_done` pulse. With every pulse come a performance count and an energy count for the core that is running.

Every epoch opens with a trial phase. Each core in turn runs for a fixed number of intervals, and the controller adds up that core's performance and energy figures. Once every core has had its turn, the controller works out which cores come close enough to the fastest one. A core qualifies when its performance sum is at least nine tenths of the highest sum. Of the qualifying cores, the one with the lowest energy sum runs for the rest of the epoch.

Exactly one core is powered at any time. Moving to a different core starts a fixed restart delay, and a busy flag stays high until the delay ends. Interval pulses that arrive during a restart count for nothing.

Top module: `core_selector`

## Requirements
- R1: After reset, core 0 is enabled, `core_id` is 0 and `busy` is low. The trial phase begins on core 0 with the epoch interval count at zero.
- R2: `core_enable` is always one-hot. Its set bit is the bit at position `core_id`, so bit i powers core i and every other core is powered down.
- R3: An interval is charged when `interval_done` is high while `busy` is low. In the trial phase the cores run in ascending index order from 0, each for SAMPLE_INTERVALS charged intervals. The charged interval that ends a core's turn changes `core_id` to the next index in the following cycle.
- R4: Each change of `core_id` raises `busy` in the same cycle. `busy` then stays high for exactly RESTART_CYCLES cycles, and `core_id` does not change while `busy` is high.
- R5: A pulse of `interval_done` while `busy` is high has no effect. It is not added to any core's sums and it does not advance the epoch interval count.
- R6: Each core's trial figures are the sums of its charged intervals. A core qualifies when perf_sum*10 >= max_perf_sum*9, which includes the exact 90% boundary.
- R7: The qualifying core with the lowest energy sum is chosen, and on an equal energy sum the lower index wins. The chosen core appears on `core_id` two cycles after the last trial interval.
- R8: Choosing the core that is already active causes no restart: `busy` stays low. This covers the last trial core being chosen, and an epoch that ends on core 0.
- R9: After EPOCH_INTERVALS charged intervals, counted from the start of the epoch, a new trial phase begins on core 0. All sums are cleared at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_done | input | 1 | One-cycle pulse marking the end of an execution interval |
| perf_count | input | PERF_W | Performance count of the active core for the interval that just ended |
| energy_count | input | ENERGY_W | Energy count of the active core for the interval that just ended |
| core_enable | output | NUM_CORES | One-hot power enable, one bit per core |
| core_id | output | $clog2(NUM_CORES) | Index of the active core |
| busy | output | 1 | High while the restart delay of a newly selected core is counting down |

## Verification
The bench builds the controller with four cores and shortened counts: two trial intervals per core, a twelve-interval epoch and a five-cycle restart. With these values several complete epochs, each with a trial phase, a decision, a run phase and a wrap back to core 0, fit into a few hundred cycles. The per-epoch sums are chosen to put a core exactly on the 90% boundary and another one step below it, to produce an energy tie between qualifying cores, and to select the last trial core so that no switch happens. In one epoch the bench sends interval pulses with large figures during every restart. If those pulses were counted they would change the selected core and shorten the epoch.

// File: rtl/core_selector_pkg.sv
package core_selector_pkg;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_DECIDE = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

endpackage

// File: rtl/cs_restart_timer.sv
module cs_restart_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/cs_pick.sv
module cs_pick #(
    parameter int N    = 4,
    parameter int ID_W = 2,
    parameter int PW   = 16,
    parameter int EW   = 16,
    parameter int MNUM = 9,
    parameter int MDEN = 10
) (
    input  logic [N-1:0][PW-1:0] acc_p,
    input  logic [N-1:0][EW-1:0] acc_e,
    output logic [ID_W-1:0]      winner
);
    localparam int MW = $clog2(MDEN + 1);
    localparam int XW = PW + MW;

    logic [PW-1:0] pmax;
    logic [N-1:0]  qual;
    logic [EW-1:0] best_e;
    logic          found;

    // highest performance sum over all cores
    always_comb begin
        pmax = '0;
        for (int i = 0; i < N; i++) begin
            if (acc_p[i] > pmax) begin
                pmax = acc_p[i];
            end
        end
    end

    // margin test without a divider
    generate
        for (genvar g = 0; g < N; g++) begin : g_qual
            assign qual[g] = (XW'(acc_p[g]) * XW'(MDEN)) >= (XW'(pmax) * XW'(MNUM));
        end
    endgenerate

    // lowest energy among qualifiers, strict compare keeps the lower index on ties
    always_comb begin
        winner = '0;
        best_e = '1;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (qual[i] && (!found || acc_e[i] < best_e)) begin
                winner = ID_W'(i);
                best_e = acc_e[i];
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/core_selector.sv
module core_selector
    import core_selector_pkg::*;
#(
    parameter int NUM_CORES        = 4,
    parameter int EPOCH_INTERVALS  = 100,
    parameter int SAMPLE_INTERVALS = 5,
    parameter int RESTART_CYCLES   = 1000,
    parameter int PERF_W           = 16,
    parameter int ENERGY_W         = 16,
    parameter int MARGIN_NUM       = 9,
    parameter int MARGIN_DEN       = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         interval_done,
    input  logic [PERF_W-1:0]            perf_count,
    input  logic [ENERGY_W-1:0]          energy_count,
    output logic [NUM_CORES-1:0]         core_enable,
    output logic [$clog2(NUM_CORES)-1:0] core_id,
    output logic                         busy
);
    localparam int ID_W   = $clog2(NUM_CORES);
    localparam int SC_W   = $clog2(SAMPLE_INTERVALS + 1);
    localparam int EC_W   = $clog2(EPOCH_INTERVALS + 1);
    localparam int SUM_PW = PERF_W + SC_W;
    localparam int SUM_EW = ENERGY_W + SC_W;

    typedef struct packed {
        phase_e                              phase;
        logic [ID_W-1:0]                     cur;
        logic [SC_W-1:0]                     scnt;
        logic [EC_W-1:0]                     ecnt;
        logic [NUM_CORES-1:0][SUM_PW-1:0]    sp;
        logic [NUM_CORES-1:0][SUM_EW-1:0]    se;
    } state_t;

    state_t          st_d, st_q;
    logic            start_restart;
    logic            charged;
    logic [ID_W-1:0] winner;

    cs_pick #(
        .N    (NUM_CORES),
        .ID_W (ID_W),
        .PW   (SUM_PW),
        .EW   (SUM_EW),
        .MNUM (MARGIN_NUM),
        .MDEN (MARGIN_DEN)
    ) u_pick (
        .acc_p  (st_q.sp),
        .acc_e  (st_q.se),
        .winner (winner)
    );

    cs_restart_timer #(
        .CYCLES (RESTART_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_restart),
        .busy  (busy)
    );

    assign charged = interval_done && !busy;

    always_comb begin
        st_d          = st_q;
        start_restart = 1'b0;
        case (st_q.phase)
            PH_SAMPLE: begin
                if (charged) begin
                    st_d.sp[st_q.cur] = st_q.sp[st_q.cur] + SUM_PW'(perf_count);
                    st_d.se[st_q.cur] = st_q.se[st_q.cur] + SUM_EW'(energy_count);
                    st_d.ecnt         = st_q.ecnt + 1'b1;
                    if (st_q.scnt == SC_W'(SAMPLE_INTERVALS - 1)) begin
                        st_d.scnt = '0;
                        if (st_q.cur == ID_W'(NUM_CORES - 1)) begin
                            st_d.phase = PH_DECIDE;
                        end else begin
                            st_d.cur      = st_q.cur + 1'b1;
                            start_restart = 1'b1;
                        end
                    end else begin
                        st_d.scnt = st_q.scnt + 1'b1;
                    end
                end
            end
            PH_DECIDE: begin
                st_d.phase    = PH_RUN;
                st_d.cur      = winner;
                start_restart = (winner != st_q.cur);
                if (charged) begin
                    st_d.ecnt = st_q.ecnt + 1'b1;
                end
            end
            PH_RUN: begin
                if (charged) begin
                    if (st_q.ecnt == EC_W'(EPOCH_INTERVALS - 1)) begin
                        st_d.ecnt     = '0;
                        st_d.scnt     = '0;
                        st_d.sp       = '0;
                        st_d.se       = '0;
                        st_d.phase    = PH_SAMPLE;
                        st_d.cur      = '0;
                        start_restart = (st_q.cur != '0);
                    end else begin
                        st_d.ecnt = st_q.ecnt + 1'b1;
                    end
                end
            end
            default: begin
                st_d.phase = PH_SAMPLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_id     = st_q.cur;
    assign core_enable = NUM_CORES'(1) << st_q.cur;

endmodule

// File: rtl/core_selector_chk.sv
module core_selector_chk #(
    parameter int NUM_CORES      = 4,
    parameter int RESTART_CYCLES = 1000
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CORES-1:0]         core_enable,
    input logic [$clog2(NUM_CORES)-1:0] core_id,
    input logic                         busy
);
    localparam int LW = $clog2(RESTART_CYCLES + 2);

    logic [LW-1:0] busy_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (busy) begin
            busy_len_q <= busy_len_q + 1'b1;
        end else begin
            busy_len_q <= '0;
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(core_enable) && core_enable[core_id]);

    a_r4_busy_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (core_id != $past(core_id)) |-> busy);

    a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(core_id));

    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (busy_len_q == LW'(RESTART_CYCLES)));

    a_r4_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len_q < LW'(RESTART_CYCLES)));

endmodule

bind core_selector core_selector_chk #(
    .NUM_CORES      (NUM_CORES),
    .RESTART_CYCLES (RESTART_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_enable (core_enable),
    .core_id     (core_id),
    .busy        (busy)
);

// File: tb/core_selector_tb.sv
module core_selector_tb;
    localparam int N  = 4;
    localparam int S  = 2;
    localparam int E  = 12;
    localparam int RC = 5;
    localparam int PW = 12;
    localparam int EW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          interval_done = 1'b0;
    logic [PW-1:0] perf_count = '0;
    logic [EW-1:0] energy_count = '0;
    logic [N-1:0]  core_enable;
    logic [1:0]    core_id;
    logic          busy;

    core_selector #(
        .NUM_CORES(N), .EPOCH_INTERVALS(E), .SAMPLE_INTERVALS(S),
        .RESTART_CYCLES(RC), .PERF_W(PW), .ENERGY_W(EW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .interval_done(interval_done),
        .perf_count(perf_count), .energy_count(energy_count),
        .core_enable(core_enable), .core_id(core_id), .busy(busy)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    int busy_cycles = 0;

    // per-epoch trial sums per core, and the selected core they imply
    int PS [4][4] = '{'{120,180,178,200}, '{100,150,140,200}, '{200,190,160,196}, '{120,180,178,200}};
    int ES [4][4] = '{'{100,80,40,90},    '{50,60,70,30},     '{40,60,10,40},     '{100,80,40,90}};
    int WIN [4]   = '{1, 3, 0, 1};

    // behavioural reference
    int m_id, m_busy, m_ph, m_s, m_e;
    int sp [4];
    int se [4];

    function automatic int ref_pick();
        int mx = 0;
        int best = -1;
        for (int i = 0; i < N; i++) if (sp[i] > mx) mx = sp[i];
        for (int i = 0; i < N; i++)
            if (sp[i] * 10 >= mx * 9 && (best < 0 || se[i] < se[best])) best = i;
        return best;
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_id = 0; m_busy = 0; m_ph = 0; m_s = 0; m_e = 0;
            for (int i = 0; i < N; i++) begin sp[i] = 0; se[i] = 0; end
        end else begin
            bit go;
            bit st;
            go = interval_done && (m_busy == 0);
            st = 1'b0;
            if (m_ph == 1) begin
                int w;
                w = ref_pick();
                st = (w != m_id);
                m_id = w;
                m_ph = 2;
                if (go) m_e++;
            end else if (go && m_ph == 0) begin
                sp[m_id] += int'(perf_count);
                se[m_id] += int'(energy_count);
                m_e++;
                m_s++;
                if (m_s == S) begin
                    m_s = 0;
                    if (m_id == N - 1) m_ph = 1;
                    else begin m_id++; st = 1'b1; end
                end
            end else if (go && m_ph == 2) begin
                m_e++;
                if (m_e == E) begin
                    m_e = 0; m_s = 0; m_ph = 0;
                    for (int i = 0; i < N; i++) begin sp[i] = 0; se[i] = 0; end
                    st = (m_id != 0);
                    m_id = 0;
                end
            end
            if (st) m_busy = RC;
            else if (m_busy > 0) m_busy--;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 core_enable", int'(core_enable), 1 << m_id);
            check("R4 busy", int'(busy), (m_busy > 0) ? 1 : 0);
            check((m_ph == 2) ? "R7 core_id" : "R3 core_id", int'(core_id), m_id);
            if (busy) busy_cycles++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic send(int p, int e);
        @(negedge clk);
        interval_done = 1'b1;
        perf_count    = PW'(p);
        energy_count  = EW'(e);
        @(negedge clk);
        interval_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // wait out a restart; optionally fire one large interval into it (R5)
    task automatic wait_ready(bit inject);
        bit done = 1'b0;
        while (m_busy > 0) begin
            if (inject && !done) begin
                interval_done = 1'b1;
                perf_count    = PW'(4000);
                energy_count  = '0;
                @(negedge clk);
                interval_done = 1'b0;
                done = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int snap;
        snap = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset core_id", int'(core_id), 0);
        check("R1 reset core_enable", int'(core_enable), 1);
        check("R1 reset busy", int'(busy), 0);
        for (int ep = 0; ep < 4; ep++) begin
            if (ep > 0) check("R9 epoch restarts on core 0", int'(core_id), 0);
            if (ep == 3) check("R8 no restart returning to core 0", busy_cycles, snap);
            for (int k = 0; k < E; k++) begin
                wait_ready(ep == 3);
                if (k == S * N) begin
                    check((ep == 0) ? "R6 margin boundary winner" :
                          (ep == 2) ? "R7 energy tie winner" :
                          (ep == 3) ? "R5 busy intervals ignored winner" : "R7 winner",
                          int'(core_id), WIN[ep]);
                end
                if (k == S * N - 1) snap = busy_cycles;
                if (k == S * N + 1 && ep == 1) check("R8 last trial core kept", busy_cycles, snap);
                if (k == E - 1) begin
                    check("R9 still on winner before epoch end", int'(core_id), WIN[ep]);
                    snap = busy_cycles;
                end
                send(PS[ep][m_id] / 2, ES[ep][m_id] / 2);
            end
        end
        wait_ready(1'b0);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule